// File: doc/BRIEF.md
# Microcontroller interrupt flag controller

This block collects four interrupt sources for a small 8-bit core: an external pin, a change detector on a 4-bit port nibble, a timer-overflow pulse and a comparator-change pulse. It holds the interrupt control register, which carries the source enables, the sticky flags and a global enable. It also holds a peripheral flag register and a peripheral enable register, each with the comparator bit at position 6. It drives an interrupt request to the core, updated once per instruction cycle, and a wake-up request while the core is asleep.

The external pin and the port nibble are asynchronous. Each passes through a synchronizer chain before edge or change detection. The external edge polarity comes from an input driven by the core's option register. The core tells the block the current clock phase, when it reads the port, when it is asleep, and when it has taken the vector. Software clears the flags through the register port.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Address 0 is the control register. Its bits, from 7 down to 0, are: global enable, peripheral enable, timer enable, external enable, port-change enable, timer flag, external flag, port-change flag. A write stores all eight bits, and a read returns them.
- R2: The external flag (bit 1) is set by a rising synchronized edge on `ext_pin` when `edge_rise`=1, and by a falling edge when `edge_rise`=0. The opposite edge has no effect. The flag stays set until software writes 0 to it.
- R3: The external flag changes from 0 to 1 only at a clock edge whose `phase` is Q4 (code 3) or Q1 (code 0). An edge detected in Q2 or Q3 is held pending until the next Q4.
- R4: A one-cycle `tmr_ovf` pulse sets the timer flag (bit 2) one cycle later, whatever the timer enable (bit 5) holds.
- R5: The port-change flag (bit 0) is set while the synchronized nibble differs from the value captured at the last `port_rd` cycle. In a cycle with `port_rd`=1 the nibble is captured and no flag is set, so a change taken in by a read is lost.
- R6: A `cmp_chg` pulse sets bit 6 of address 1 (peripheral flags). Bit 6 of address 2 is the comparator enable. A comparator request reaches `irq` and `wake` only when the peripheral enable (control bit 6) is also 1.
- R7: `irq` is a register updated only at a Q1 (code 0) edge. It loads the global enable ANDed with the OR of the enabled requests: timer (bits 5 and 2), external (bits 4 and 1), port change (bits 3 and 0) and the comparator term of R6.
- R8: `wake` is registered every cycle as `sleeping` ANDed with the same OR of enabled requests. The global enable does not gate it.
- R9: A `vec_taken` pulse clears the global enable (bit 7) in the following cycle, overriding a write that sets it in the same cycle.
- R10: `rst_cold` clears the control register to 00h and both peripheral registers to 0. `rst_warm` clears control bits 7:1 and the peripheral registers, and keeps the port-change flag. Both resets drive `irq` and `wake` to 0.
- R11: When a hardware set and a software write of 0 hit the same flag in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_warm | input | 1 | Synchronous reset that keeps the port-change flag |
| rst_cold | input | 1 | Synchronous power-on reset |
| phase | input | 2 | Current clock phase: 0=Q1, 1=Q2, 2=Q3, 3=Q4 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 peripheral flags, 2 peripheral enables |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (unused bits and address 3 read 0) |
| edge_rise | input | 1 | 1 selects the rising external edge, 0 the falling edge |
| ext_pin | input | 1 | Raw external interrupt pin |
| port_hi | input | PORT_W | Raw upper port nibble |
| port_rd | input | 1 | The core is reading the port in this cycle |
| tmr_ovf | input | 1 | Timer overflow pulse |
| cmp_chg | input | 1 | Comparator output change pulse |
| sleeping | input | 1 | The core is asleep |
| vec_taken | input | 1 | The core is branching to the interrupt vector |
| irq | output | 1 | Interrupt request, updated at Q1 |
| wake | output | 1 | Wake-up request |

## Verification
A corrupted flag or enable shows on `reg_rdata` at address 0 on the next cycle. It shows on `wake` one cycle later, and on `irq` at the next Q1, which is up to four cycles away. A pending external edge that is lost or set too early shows only as a bit-1 transition in the wrong phase, so the bench checks the phase of every such rise. A port-change capture that goes wrong shows up as a spurious or missing bit 0 some cycles after a read. The bench therefore holds reads across nibble changes, and also changes the nibble without any read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_PFLG = 2'd1;
  localparam logic [1:0] A_PEN  = 2'd2;

  localparam int B_GIE  = 7;
  localparam int B_PEIE = 6;
  localparam int B_TIE  = 5;
  localparam int B_XIE  = 4;
  localparam int B_PCIE = 3;
  localparam int B_TIF  = 2;
  localparam int B_XIF  = 1;
  localparam int B_PCIF = 0;
  localparam int B_CMP  = 6;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic rise_sel,
  input  logic window,
  output logic set_flag
);
  logic prev_q;
  logic pend_q;
  logic evt;

  always_comb begin
    evt      = rise_sel ? (din & ~prev_q) : (~din & prev_q);
    set_flag = (pend_q | evt) & window & ~rst;
  end

  always_ff @(posedge clk) begin
    prev_q <= din;
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (pend_q | evt) & ~window;
  end
endmodule

// File: rtl/irqc_chg.sv
module irqc_chg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         rd_strobe,
  output logic         set_flag
);
  logic [W-1:0] snap_q;

  assign set_flag = (din != snap_q) & ~rd_strobe & ~rst;

  always_ff @(posedge clk) begin
    if (rst || rd_strobe) snap_q <= din;
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqc_pkg::*;
#(
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_warm,
  input  logic              rst_cold,
  input  logic [1:0]        phase,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              edge_rise,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_hi,
  input  logic              port_rd,
  input  logic              tmr_ovf,
  input  logic              cmp_chg,
  input  logic              sleeping,
  input  logic              vec_taken,
  output logic              irq,
  output logic              wake
);
  logic              rst_any;
  logic              ext_s;
  logic [PORT_W-1:0] port_s;
  logic              window;
  logic              x_set;
  logic              pc_set;
  logic [REG_W-1:0]  ctrl_q, ctrl_n;
  logic              cmpf_q, cmpe_q;
  logic              irq_q, wake_q;
  logic              req_any;

  assign rst_any = rst_warm | rst_cold;
  assign window  = (phase == PH_Q4) || (phase == PH_Q1);

  irqc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ext (
    .clk(clk), .d(ext_pin), .q(ext_s)
  );

  irqc_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync_port (
    .clk(clk), .d(port_hi), .q(port_s)
  );

  irqc_edge u_edge (
    .clk(clk), .rst(rst_any), .din(ext_s), .rise_sel(edge_rise),
    .window(window), .set_flag(x_set)
  );

  irqc_chg #(.W(PORT_W)) u_chg (
    .clk(clk), .rst(rst_any), .din(port_s), .rd_strobe(port_rd),
    .set_flag(pc_set)
  );

  always_comb begin
    req_any = (ctrl_q[B_TIE]  & ctrl_q[B_TIF])  |
              (ctrl_q[B_XIE]  & ctrl_q[B_XIF])  |
              (ctrl_q[B_PCIE] & ctrl_q[B_PCIF]) |
              (ctrl_q[B_PEIE] & cmpf_q & cmpe_q);
  end

  always_comb begin
    ctrl_n = ctrl_q;
    if (reg_wr && reg_addr == A_CTRL) ctrl_n = reg_wdata;
    if (x_set)     ctrl_n[B_XIF]  = 1'b1;
    if (pc_set)    ctrl_n[B_PCIF] = 1'b1;
    if (tmr_ovf)   ctrl_n[B_TIF]  = 1'b1;
    if (vec_taken) ctrl_n[B_GIE]  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      ctrl_q <= {{(REG_W-1){1'b0}}, rst_cold ? 1'b0 : ctrl_q[B_PCIF]};
      cmpf_q <= 1'b0;
      cmpe_q <= 1'b0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      if (cmp_chg)                            cmpf_q <= 1'b1;
      else if (reg_wr && reg_addr == A_PFLG)  cmpf_q <= reg_wdata[B_CMP];
      if (reg_wr && reg_addr == A_PEN)        cmpe_q <= reg_wdata[B_CMP];
      if (phase == PH_Q1) irq_q <= ctrl_q[B_GIE] & req_any;
      wake_q <= sleeping & req_any;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_PFLG:  reg_rdata[B_CMP] = cmpf_q;
      A_PEN:   reg_rdata[B_CMP] = cmpe_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq  = irq_q;
  assign wake = wake_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [1:0] phase,
  input logic       tmr_ovf,
  input logic       cmp_chg,
  input logic       sleeping,
  input logic       vec_taken,
  input logic       irq,
  input logic       wake,
  input logic [7:0] ctrl_q,
  input logic       cmpf_q
);
  AST_IRQ_ONLY_AT_Q1: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_Q1) |=> $stable(irq)); // R7
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(ctrl_q[B_GIE])); // R7
  AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(sleeping)); // R8
  AST_TMR_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf |=> ctrl_q[B_TIF]); // R4
  AST_CMP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    cmp_chg |=> cmpf_q); // R6
  AST_VEC_CLEARS_GIE: assert property (@(posedge clk) disable iff (rst)
    vec_taken |=> !ctrl_q[B_GIE]); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl_q[7:1] == 7'd0 && !cmpf_q)); // R10
endmodule

bind irq_flag_ctrl irqc_chk u_chk (
  .clk(clk), .rst(rst_any), .phase(phase), .tmr_ovf(tmr_ovf),
  .cmp_chg(cmp_chg), .sleeping(sleeping), .vec_taken(vec_taken),
  .irq(irq), .wake(wake), .ctrl_q(ctrl_q), .cmpf_q(cmpf_q)
);

// File: tb/test_irq_flag_ctrl.sv
module test_irq_flag_ctrl;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_warm = 1'b0, rst_cold = 1'b1;
  logic [1:0] phase = 2'd0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       edge_rise = 1'b1, ext_pin = 1'b0;
  logic [3:0] port_hi = 4'd0;
  logic       port_rd = 1'b0, tmr_ovf = 1'b0, cmp_chg = 1'b0;
  logic       sleeping = 1'b0, vec_taken = 1'b0;
  logic       irq, wake;

  int checks = 0, fails = 0;
  bit done = 0;

  irq_flag_ctrl i_irq_flag_ctrl (
    .clk(clk), .rst_warm(rst_warm), .rst_cold(rst_cold), .phase(phase),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .edge_rise(edge_rise), .ext_pin(ext_pin),
    .port_hi(port_hi), .port_rd(port_rd), .tmr_ovf(tmr_ovf),
    .cmp_chg(cmp_chg), .sleeping(sleeping), .vec_taken(vec_taken),
    .irq(irq), .wake(wake)
  );

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  always @(negedge clk) begin
    cyc   <= cyc + 1;
    phase <= 2'((cyc + 1) % 4);
  end

  // behavioural reference model, stepped on every rising edge
  logic       m_x1 = 0, m_x2 = 0, m_xp = 0, m_pend = 0;
  logic [3:0] m_p1 = 0, m_p2 = 0, m_snap = 0;
  logic [7:0] m_ctrl = 0;
  logic       m_cf = 0, m_ce = 0, m_irq = 0, m_wake = 0;
  logic       live = 0;
  logic [1:0] edge_ph = 0;
  logic       edge_wr0 = 0;

  always @(posedge clk) begin
    logic ox2, oxp, evt, win, req;
    logic [3:0] op2;
    logic [7:0] nc;
    ox2 = m_x2; oxp = m_xp; op2 = m_p2;
    m_xp = m_x2; m_x2 = m_x1; m_x1 = ext_pin;
    m_p2 = m_p1; m_p1 = port_hi;
    edge_ph = phase;
    edge_wr0 = reg_wr && reg_addr == 2'd0;
    if (rst_warm || rst_cold) begin
      m_pend = 0; m_snap = op2;
      m_ctrl = {7'd0, rst_cold ? 1'b0 : m_ctrl[0]};
      m_cf = 0; m_ce = 0; m_irq = 0; m_wake = 0;
      live = 1;
    end else begin
      evt = edge_rise ? (ox2 && !oxp) : (!ox2 && oxp);
      win = (phase == 2'd3) || (phase == 2'd0);
      req = (m_ctrl[5] && m_ctrl[2]) || (m_ctrl[4] && m_ctrl[1]) ||
            (m_ctrl[3] && m_ctrl[0]) || (m_ctrl[6] && m_cf && m_ce);
      if (phase == 2'd0) m_irq = m_ctrl[7] && req;
      m_wake = sleeping && req;
      nc = m_ctrl;
      if (reg_wr && reg_addr == 2'd0) nc = reg_wdata;
      if ((m_pend || evt) && win) nc[1] = 1'b1;
      m_pend = (m_pend || evt) && !win;
      if (op2 != m_snap && !port_rd) nc[0] = 1'b1;
      if (port_rd) m_snap = op2;
      if (tmr_ovf) nc[2] = 1'b1;
      if (vec_taken) nc[7] = 1'b0;
      m_ctrl = nc;
      if (cmp_chg) m_cf = 1'b1;
      else if (reg_wr && reg_addr == 2'd1) m_cf = reg_wdata[6];
      if (reg_wr && reg_addr == 2'd2) m_ce = reg_wdata[6];
    end
  end

  logic [7:0] prev_rd = 0;
  logic [1:0] prev_addr = 0;
  always @(posedge clk) begin
    logic [7:0] exp_rd;
    #(CLK_P/4);
    if (live && !rst_warm && !rst_cold) begin
      case (reg_addr)
        2'd0: exp_rd = m_ctrl;
        2'd1: exp_rd = {1'b0, m_cf, 6'd0};
        2'd2: exp_rd = {1'b0, m_ce, 6'd0};
        default: exp_rd = 8'd0;
      endcase
      checks++;
      if (reg_rdata !== exp_rd) begin
        fails++;
        $display("FAIL R1 R2 R5 reg_rdata addr %0d: got %h exp %h", reg_addr, reg_rdata, exp_rd);
      end
      checks++;
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL R7 irq: got %b exp %b", irq, m_irq);
      end
      checks++;
      if (wake !== m_wake) begin
        fails++;
        $display("FAIL R8 wake: got %b exp %b", wake, m_wake);
      end
      if (reg_addr == 2'd0 && prev_addr == 2'd0 && reg_rdata[1] && !prev_rd[1] && !edge_wr0) begin
        checks++;
        if (!(edge_ph == 2'd3 || edge_ph == 2'd0)) begin
          fails++;
          $display("FAIL R3 external flag rose at phase %0d exp 3 or 0", edge_ph);
        end
      end
    end
    prev_rd = reg_rdata;
    prev_addr = reg_addr;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 2'd0;
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic rd_at(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
    @(negedge clk); reg_addr = 2'd0;
  endtask

  initial begin
    logic [7:0] v;
    step(5);
    rst_cold = 0;
    step(2);
    chk("R10 cold reset ctrl", reg_rdata, 8'h00);
    chk("R10 cold reset irq", {7'd0, irq}, 8'h00);

    wr(2'd0, 8'hF8); step(1);
    chk("R1 ctrl readback", reg_rdata, 8'hF8);
    @(negedge clk); tmr_ovf = 1; @(negedge clk); tmr_ovf = 0;
    chk("R4 timer flag set", reg_rdata, 8'hFC);
    step(6);
    chk("R7 irq raised", {7'd0, irq}, 8'h01);
    @(negedge clk); vec_taken = 1; @(negedge clk); vec_taken = 0;
    chk("R9 gie cleared", reg_rdata, 8'h7C);
    step(6);
    chk("R7 irq dropped without gie", {7'd0, irq}, 8'h00);

    wr(2'd0, 8'h00); step(1);
    ext_pin = 1; step(10);
    chk("R2 rising edge sets flag", reg_rdata, 8'h02);
    wr(2'd0, 8'h00); step(1);
    chk("R2 software clear", reg_rdata, 8'h00);
    ext_pin = 0; step(10);
    chk("R2 falling edge ignored in rising mode", reg_rdata, 8'h00);
    edge_rise = 0; ext_pin = 1; step(10);
    chk("R2 rising edge ignored in falling mode", reg_rdata, 8'h00);
    ext_pin = 0; step(10);
    chk("R2 falling edge sets flag", reg_rdata, 8'h02);

    @(negedge clk);
    reg_wr = 1; reg_wdata = 8'h00; tmr_ovf = 1;
    @(negedge clk);
    reg_wr = 0; tmr_ovf = 0;
    chk("R11 R4 set beats write clear", reg_rdata, 8'h04);

    wr(2'd0, 8'h00);
    port_hi = 4'h5; step(6);
    chk("R5 port change sets flag", reg_rdata, 8'h01);
    @(negedge clk); port_rd = 1; @(negedge clk); port_rd = 0;
    wr(2'd0, 8'h00); step(3);
    chk("R5 no flag after read matches", reg_rdata, 8'h00);
    @(negedge clk); port_rd = 1; port_hi = 4'hA; step(8);
    port_rd = 0; step(3);
    chk("R5 change during read lost", reg_rdata, 8'h00);

    @(negedge clk); cmp_chg = 1; @(negedge clk); cmp_chg = 0;
    rd_at(2'd1, v);
    chk("R6 comparator flag", v, 8'h40);
    wr(2'd2, 8'h40);
    rd_at(2'd2, v);
    chk("R6 comparator enable", v, 8'h40);
    wr(2'd0, 8'h80); step(8);
    chk("R6 blocked by peripheral enable", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'hC0); step(8);
    chk("R6 comparator irq", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);

    wr(2'd0, 8'h12); sleeping = 1; step(3);
    chk("R8 wake without gie", {7'd0, wake}, 8'h01);
    chk("R7 no irq without gie", {7'd0, irq}, 8'h00);
    sleeping = 0; step(2);
    chk("R8 wake drops when awake", {7'd0, wake}, 8'h00);

    wr(2'd0, 8'hB9);
    @(negedge clk); cmp_chg = 1; @(negedge clk); cmp_chg = 0;
    rst_warm = 1; step(3); rst_warm = 0; step(1);
    chk("R10 warm reset keeps bit0", reg_rdata, 8'h01);
    rd_at(2'd1, v);
    chk("R10 warm reset clears comparator flag", v, 8'h00);
    rst_cold = 1; step(3); rst_cold = 0; step(1);
    chk("R10 cold reset clears bit0", reg_rdata, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) ext_pin = ~ext_pin;
      if ($urandom_range(0, 9) == 0) port_hi = 4'($urandom);
      if ($urandom_range(0, 63) == 0) edge_rise = ~edge_rise;
      port_rd   = ($urandom_range(0, 5) == 0);
      tmr_ovf   = ($urandom_range(0, 15) == 0);
      cmp_chg   = ($urandom_range(0, 15) == 0);
      vec_taken = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 31) == 0) sleeping = ~sleeping;
      reg_wr    = ($urandom_range(0, 9) == 0);
      reg_addr  = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd0;
      reg_wdata = 8'($urandom);
      if ($urandom_range(0, 499) == 0) rst_warm = 1; else rst_warm = 0;
    end
    @(negedge clk);
    reg_wr = 0; port_rd = 0; tmr_ovf = 0; cmp_chg = 0; vec_taken = 0; rst_warm = 0;
    step(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule